// File: doc/BRIEF.md
# Memory-Mapped ATA Task-File Bridge

This block sits between a memory-mapped host bus and the register interface of an ATA/IDE device. The host issues byte, half-word or word reads and writes inside a 4 KB window. The bridge decodes a sparse layout in which registers sit 16 bytes apart. It turns each mapped access into a single strobe cycle on the device side, with chip selects, a 3-bit register address and data. Accesses to holes in the map never reach the device: reads return all ones of the access width and writes are dropped.

The data port accepts only half-word and word accesses. Its bytes are reversed in both directions, so a big-endian host sees the data stream in the right order. Two indices alias the device-control register; reading either one returns alternate status. The bridge keeps its own copy of the interrupt-disable bit and a pending-interrupt flag. It presents the device interrupt to the host only while interrupts are enabled.

Top module: `mmio_ata_bridge`

## Requirements
- R1: The register index is host_addr[11:4]. Address bits above bit 11 and below bit 4 do not affect decoding.
- R2: A byte access to index 1..7 issues one strobe with dev_cs=2'b01 (bit 0 selects the task file, bit 1 the control block) and dev_addr equal to the index. The write data is host_wdata[7:0] on dev_wdata[7:0] with the upper bits zero. The read data is dev_rdata[7:0], zero-extended.
- R3: A byte access to index 8 or index 22 issues one strobe with dev_cs=2'b10 and dev_addr=6. A write reaches device control; a read returns alternate status, zero-extended.
- R4: A byte access to any other index, index 0 included, issues no device strobe. A read returns 32'h000000FF.
- R5: A half-word (size code 1) or word (size code 2) access to index 0 issues one strobe with dev_cs=2'b01 and dev_addr=0. dev_wide is 0 for a half-word and 1 for a word.
- R6: A half-word or word access to any index other than 0 issues no strobe. A read returns 32'h0000FFFF for a half-word and 32'hFFFFFFFF for a word.
- R7: Data-port bytes are reversed in both directions. A half-word swaps bits [15:8] and [7:0], leaving the upper half zero. A word reverses all four bytes.
- R8: A request sampled at clock edge k drives a device strobe for exactly the cycle after edge k. host_ready pulses for one cycle after edge k+1, with host_rdata valid during that pulse. A new request may be made on every cycle.
- R9: A rising edge of dev_intrq sets a pending flag. A status read (byte read at index 7) clears it at the end of its strobe cycle. A read of alternate status leaves it set, and a rising edge in the clearing cycle wins.
- R10: host_irq is high when the flag is pending and the interrupt-disable bit is 0. The interrupt-disable bit is bit 1 of the last device-control write and resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 32 | Host byte address |
| host_size | input | 2 | 0 byte, 1 half-word, 2 word |
| host_rd | input | 1 | Read request, one cycle |
| host_wr | input | 1 | Write request, one cycle (wins over host_rd) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | One-cycle completion pulse |
| host_irq | output | 1 | Gated interrupt to the host |
| dev_cs | output | 2 | Chip selects: bit 0 task file, bit 1 control block |
| dev_addr | output | 3 | Device register address |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_wide | output | 1 | Data-port transfer is 32 bits |
| dev_wdata | output | 32 | Device write data |
| dev_rdata | input | 32 | Device read data, sampled at the end of the strobe cycle |
| dev_intrq | input | 1 | Interrupt request from the device |

## Verification
Device strobes, select, address and write data are due in the cycle after the edge that samples the request. host_ready and host_rdata are due one cycle later. The interrupt flag and the disable bit change at the edge that ends the strobe cycle, so host_irq changes together with the ready pulse. The bench drives inputs on falling edges. It samples strobe signals at the falling edge after one rising edge, and ready, data and interrupt at the falling edge after two. A pipelined run of three back-to-back reads checks that each stage carries the right access.

// File: rtl/ata_bridge_pkg.sv
// Shared encodings for the memory-mapped ATA bridge.
// Assumes host size codes 0/1/2 for byte/half-word/word; code 3 is unused.
package ata_bridge_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam logic [1:0] CS_NONE = 2'b00;
    localparam logic [1:0] CS_TASK = 2'b01;
    localparam logic [1:0] CS_CTRL = 2'b10;
    localparam logic [2:0] CTRL_REG_ADDR = 3'd6;

    typedef struct packed {
        logic       hit;
        logic       is_data;
        logic [1:0] cs;
        logic [2:0] reg_addr;
    } dec_t;
endpackage

// File: rtl/ata_addr_decode.sv
// Address decoder: maps a host address and size onto a device register.
// Assumes registers on a (1<<STRIDE_BITS)-byte stride inside a
// (1<<WIN_BITS)-byte window; purely combinational.
module ata_addr_decode
    import ata_bridge_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_BITS = 4,
    parameter int CTRL_IDX_A  = 8,
    parameter int CTRL_IDX_B  = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output dec_t              dec
);
    localparam int IDX_W = WIN_BITS - STRIDE_BITS;

    logic [IDX_W-1:0] idx;
    assign idx = addr[WIN_BITS-1:STRIDE_BITS];

    // Classify the access by size and index.
    always_comb begin
        dec = '0;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                if (idx >= IDX_W'(1) && idx <= IDX_W'(7)) begin
                    dec.hit      = 1'b1;
                    dec.cs       = CS_TASK;
                    dec.reg_addr = idx[2:0];
                end else if (idx == IDX_W'(CTRL_IDX_A) || idx == IDX_W'(CTRL_IDX_B)) begin
                    dec.hit      = 1'b1;
                    dec.cs       = CS_CTRL;
                    dec.reg_addr = CTRL_REG_ADDR;
                end
            end
            SZ_HALF, SZ_WORD: begin
                if (idx == '0) begin
                    dec.hit     = 1'b1;
                    dec.is_data = 1'b1;
                    dec.cs      = CS_TASK;
                end
            end
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/ata_lane_swap.sv
// Byte-lane reverser: output byte i is input byte LANES-1-i.
// Assumes 8-bit lanes; purely combinational.
module ata_lane_swap #(
    parameter int LANES = 4
) (
    input  logic [LANES*8-1:0] din,
    output logic [LANES*8-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[i*8 +: 8] = din[(LANES-1-i)*8 +: 8];
    end
endmodule

// File: rtl/ata_irq_gate.sv
// Interrupt gate: latches device interrupt edges and masks them with
// the interrupt-disable bit. Assumes clear and control-write pulses
// arrive in the device strobe cycle.
module ata_irq_gate #(
    parameter int DATA_W   = 32,
    parameter int NIEN_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              intrq,
    input  logic              clr,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] ctrl_data,
    output logic              irq
);
    logic intrq_prev;
    logic pending;
    logic irq_dis;

    // Track the previous request level, also while in reset.
    always_ff @(posedge clk) begin
        intrq_prev <= intrq;
    end

    // Pending flag: a rising edge sets it and wins over a status-read clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= (pending & ~clr) | (intrq & ~intrq_prev);
    end

    // Shadow copy of the interrupt-disable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_dis <= 1'b0;
        else if (ctrl_wr) irq_dis <= ctrl_data[NIEN_BIT];
    end

    assign irq = pending & ~irq_dis;
endmodule

// File: rtl/mmio_ata_bridge.sv
// Memory-mapped host to ATA task-file bridge. Two pipeline stages:
// request -> device strobe cycle -> host ready. Assumes one-cycle host
// requests and a device that returns read data within its strobe cycle.
module mmio_ata_bridge
    import ata_bridge_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WIN_BITS    = 12,
    parameter int STRIDE_BITS = 4,
    parameter int CTRL_IDX_A  = 8,
    parameter int CTRL_IDX_B  = 22,
    parameter int NIEN_BIT    = 1,
    parameter int STATUS_REG  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_size,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    output logic              host_ready,
    output logic              host_irq,
    output logic [1:0]        dev_cs,
    output logic [2:0]        dev_addr,
    output logic              dev_rd,
    output logic              dev_wr,
    output logic              dev_wide,
    output logic [31:0]       dev_wdata,
    input  logic [31:0]       dev_rdata,
    input  logic              dev_intrq
);
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;

    dec_t dec;
    logic req;
    logic [HALF_W-1:0] wr_sw16, rd_sw16;
    logic [DATA_W-1:0] wr_sw32, rd_sw32;
    logic [DATA_W-1:0] wdata_nxt;

    // Stage-1 bookkeeping for the completion stage.
    logic       s1_vld;
    logic       s1_rd;
    logic       s1_hit;
    logic       s1_data;
    logic [1:0] s1_size;
    logic [DATA_W-1:0] rdata_nxt;

    ata_addr_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS),
        .CTRL_IDX_A(CTRL_IDX_A), .CTRL_IDX_B(CTRL_IDX_B)
    ) u_dec (
        .addr(host_addr), .size(host_size), .dec(dec)
    );

    ata_lane_swap #(.LANES(2)) u_wsw16 (.din(host_wdata[HALF_W-1:0]), .dout(wr_sw16));
    ata_lane_swap #(.LANES(4)) u_wsw32 (.din(host_wdata), .dout(wr_sw32));
    ata_lane_swap #(.LANES(2)) u_rsw16 (.din(dev_rdata[HALF_W-1:0]), .dout(rd_sw16));
    ata_lane_swap #(.LANES(4)) u_rsw32 (.din(dev_rdata), .dout(rd_sw32));

    assign req = host_rd | host_wr;

    // Select device write data by access kind.
    always_comb begin
        if (!dec.is_data)                       wdata_nxt = {24'h0, host_wdata[7:0]};
        else if (host_size == 2'(SZ_WORD))      wdata_nxt = wr_sw32;
        else                                    wdata_nxt = {{HALF_W{1'b0}}, wr_sw16};
    end

    // Stage 1: drive the device strobe cycle and remember the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_rd    <= 1'b0;
            dev_wr    <= 1'b0;
            dev_cs    <= CS_NONE;
            dev_addr  <= '0;
            dev_wide  <= 1'b0;
            dev_wdata <= '0;
            s1_vld    <= 1'b0;
            s1_rd     <= 1'b0;
            s1_hit    <= 1'b0;
            s1_data   <= 1'b0;
            s1_size   <= '0;
        end else begin
            dev_rd    <= host_rd & ~host_wr & dec.hit;
            dev_wr    <= host_wr & dec.hit;
            dev_cs    <= (req & dec.hit) ? dec.cs : CS_NONE;
            dev_addr  <= dec.reg_addr;
            dev_wide  <= dec.is_data & (host_size == 2'(SZ_WORD));
            dev_wdata <= host_wr ? wdata_nxt : '0;
            s1_vld    <= req;
            s1_rd     <= host_rd & ~host_wr;
            s1_hit    <= dec.hit;
            s1_data   <= dec.is_data;
            s1_size   <= host_size;
        end
    end

    // Form the read result: device data, swapped data, or an all-ones fill.
    always_comb begin
        if (!s1_rd)                                rdata_nxt = '0;
        else if (s1_hit && s1_data && s1_size == 2'(SZ_WORD)) rdata_nxt = rd_sw32;
        else if (s1_hit && s1_data)                rdata_nxt = {{HALF_W{1'b0}}, rd_sw16};
        else if (s1_hit)                           rdata_nxt = {24'h0, dev_rdata[7:0]};
        else if (s1_size == 2'(SZ_BYTE))           rdata_nxt = 32'h0000_00FF;
        else if (s1_size == 2'(SZ_HALF))           rdata_nxt = 32'h0000_FFFF;
        else                                       rdata_nxt = 32'hFFFF_FFFF;
    end

    // Stage 2: return the ready pulse and read data to the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_ready <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ready <= s1_vld;
            host_rdata <= rdata_nxt;
        end
    end

    logic status_rd;
    logic ctrl_wr;
    assign status_rd = dev_rd & (dev_cs == CS_TASK) & (dev_addr == 3'(STATUS_REG));
    assign ctrl_wr   = dev_wr & (dev_cs == CS_CTRL);

    ata_irq_gate #(.DATA_W(DATA_W), .NIEN_BIT(NIEN_BIT)) u_irq (
        .clk(clk), .rst_n(rst_n), .intrq(dev_intrq), .clr(status_rd),
        .ctrl_wr(ctrl_wr), .ctrl_data(dev_wdata), .irq(host_irq)
    );
endmodule

// File: rtl/mmio_ata_bridge_chk.sv
// Protocol checker for mmio_ata_bridge, attached by bind.
// Assumes host_rd/host_wr are one-cycle request pulses.
module mmio_ata_bridge_chk #(
    parameter int NIEN_BIT = 1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        host_rd,
    input logic        host_wr,
    input logic        host_ready,
    input logic        host_irq,
    input logic [1:0]  dev_cs,
    input logic [2:0]  dev_addr,
    input logic        dev_rd,
    input logic        dev_wr,
    input logic [31:0] dev_wdata,
    input logic        dev_intrq
);
    p_strobe_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd || dev_wr) |-> $past(host_rd || host_wr));

    p_ready_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> $past(host_rd || host_wr, 2));

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd && dev_wr));

    p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd || dev_wr) |-> $countones(dev_cs) == 1);

    p_no_select_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd || dev_wr) |-> dev_cs == 2'b00);

    p_ctrl_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_rd || dev_wr) && dev_cs == 2'b10) |-> dev_addr == 3'd6);

    p_status_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd && dev_cs == 2'b01 && dev_addr == 3'd7 && !(dev_intrq && !$past(dev_intrq)))
        |=> !host_irq);

    p_disable_masks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_wr && dev_cs == 2'b10 && dev_wdata[NIEN_BIT]) |=> !host_irq);
endmodule

bind mmio_ata_bridge mmio_ata_bridge_chk #(.NIEN_BIT(NIEN_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_ready(host_ready), .host_irq(host_irq), .dev_cs(dev_cs),
    .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_wr(dev_wr),
    .dev_wdata(dev_wdata), .dev_intrq(dev_intrq)
);

// File: tb/sim_mmio_ata_bridge.sv
// Directed bench for mmio_ata_bridge: one task per scenario.
module sim_mmio_ata_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic        host_irq;
    logic [1:0]  dev_cs;
    logic [2:0]  dev_addr;
    logic        dev_rd;
    logic        dev_wr;
    logic        dev_wide;
    logic [31:0] dev_wdata;
    logic [31:0] dev_rdata;
    logic        dev_intrq = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    // Strobe-cycle and completion snapshots of the last access.
    logic        s_rd, s_wr, s_wide, r_ready;
    logic [1:0]  s_cs;
    logic [2:0]  s_addr;
    logic [31:0] s_wdata, r_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Device model: task-file reg i reads B0+i, control block 5A, data port 11223344.
    always_comb begin
        if (dev_cs == 2'b01 && dev_addr == 3'd0) dev_rdata = 32'h1122_3344;
        else if (dev_cs == 2'b01)                dev_rdata = {24'hEEEEEE, 5'b10110, dev_addr};
        else if (dev_cs == 2'b10)                dev_rdata = 32'hEEEE_EE5A;
        else                                     dev_rdata = 32'hDEAD_BEEF;
    end

    mmio_ata_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_size(host_size),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_ready(host_ready), .host_irq(host_irq),
        .dev_cs(dev_cs), .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_wr(dev_wr),
        .dev_wide(dev_wide), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
        .dev_intrq(dev_intrq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive at a falling edge, snapshot strobe and completion cycles.
    task automatic access(input logic [31:0] a, input logic [1:0] sz,
                          input logic wr, input logic [31:0] wd);
        @(negedge clk);
        host_addr = a; host_size = sz; host_rd = ~wr; host_wr = wr; host_wdata = wd;
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        s_rd = dev_rd; s_wr = dev_wr; s_cs = dev_cs; s_addr = dev_addr;
        s_wide = dev_wide; s_wdata = dev_wdata;
        @(negedge clk);
        r_ready = host_ready; r_data = host_rdata;
    endtask

    task automatic t_reset;
        check("R8 reset ready", {31'b0, host_ready}, 32'h0);
        check("R10 reset irq", {31'b0, host_irq}, 32'h0);
        check("R8 reset strobes", {28'b0, dev_rd, dev_wr, dev_cs}, 32'h0);
    endtask

    task automatic t_taskfile;
        access(32'h0000_0030, 2'd0, 1'b0, '0);
        check("R2 rd strobe", {27'b0, s_rd, s_wr, s_cs, 1'b0}, {27'b0, 1'b1, 1'b0, 2'b01, 1'b0});
        check("R2 rd addr", {29'b0, s_addr}, 32'd3);
        check("R2 rd data", r_data, 32'h0000_00B3);
        check("R8 ready", {31'b0, r_ready}, 32'h1);
        access(32'h0000_0050, 2'd0, 1'b1, 32'h1234_5678);
        check("R2 wr strobe", {29'b0, s_wr, s_cs}, {29'b0, 1'b1, 2'b01});
        check("R2 wr addr", {29'b0, s_addr}, 32'd5);
        check("R2 wr data", s_wdata, 32'h0000_0078);
        access(32'hABCD_5079, 2'd0, 1'b0, '0);
        check("R1 upper/low bits ignored addr", {29'b0, s_addr}, 32'd7);
        check("R1 upper/low bits ignored data", r_data, 32'h0000_00B7);
    endtask

    task automatic t_ctrl;
        access(32'h0000_0080, 2'd0, 1'b0, '0);
        check("R3 idx8 rd", {28'b0, s_rd, s_cs, 1'b0}, {28'b0, 1'b1, 2'b10, 1'b0});
        check("R3 idx8 addr", {29'b0, s_addr}, 32'd6);
        check("R3 idx8 data", r_data, 32'h0000_005A);
        access(32'h0000_0160, 2'd0, 1'b1, 32'h0000_0000);
        check("R3 idx22 wr", {28'b0, s_wr, s_cs, 1'b0}, {28'b0, 1'b1, 2'b10, 1'b0});
        check("R3 idx22 addr", {29'b0, s_addr}, 32'd6);
    endtask

    task automatic t_unmapped;
        access(32'h0000_0000, 2'd0, 1'b0, '0);
        check("R4 idx0 byte no strobe", {29'b0, s_rd, s_cs}, 32'h0);
        check("R4 idx0 byte fill", r_data, 32'h0000_00FF);
        access(32'h0000_0090, 2'd0, 1'b1, 32'hFF);
        check("R4 idx9 wr no strobe", {29'b0, s_wr, s_cs}, 32'h0);
        check("R4 idx9 ready", {31'b0, r_ready}, 32'h1);
        access(32'h0000_0010, 2'd1, 1'b0, '0);
        check("R6 half fill", r_data, 32'h0000_FFFF);
        check("R6 half no strobe", {29'b0, s_rd, s_cs}, 32'h0);
        access(32'h0000_0020, 2'd2, 1'b0, '0);
        check("R6 word fill", r_data, 32'hFFFF_FFFF);
        access(32'h0000_0020, 2'd2, 1'b1, 32'h1);
        check("R6 word wr no strobe", {29'b0, s_wr, s_cs}, 32'h0);
    endtask

    task automatic t_data;
        access(32'h0000_0000, 2'd1, 1'b0, '0);
        check("R5 half rd strobe", {27'b0, s_rd, s_cs, s_wide, 1'b0}, {27'b0, 1'b1, 2'b01, 1'b0, 1'b0});
        check("R7 half rd swap", r_data, 32'h0000_4433);
        access(32'h0000_0000, 2'd2, 1'b0, '0);
        check("R5 word rd wide", {31'b0, s_wide}, 32'h1);
        check("R7 word rd swap", r_data, 32'h4433_2211);
        access(32'h0000_0004, 2'd1, 1'b1, 32'h5555_ABCD);
        check("R7 half wr swap", s_wdata, 32'h0000_CDAB);
        check("R5 half wr addr", {28'b0, s_wr, s_addr}, {28'b0, 1'b1, 3'd0});
        access(32'h0000_0000, 2'd2, 1'b1, 32'h0102_0304);
        check("R7 word wr swap", s_wdata, 32'h0403_0201);
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        host_addr = 32'h10; host_size = 2'd0; host_rd = 1'b1;
        @(negedge clk);
        check("R8 b2b strobe1", {29'b0, dev_addr}, 32'd1);
        host_addr = 32'h20;
        @(negedge clk);
        check("R8 b2b strobe2", {29'b0, dev_addr}, 32'd2);
        check("R8 b2b data1", host_rdata, 32'h0000_00B1);
        host_addr = 32'h30;
        @(negedge clk);
        host_rd = 1'b0;
        check("R8 b2b strobe3", {29'b0, dev_addr}, 32'd3);
        check("R8 b2b data2", host_rdata, 32'h0000_00B2);
        @(negedge clk);
        check("R8 b2b data3", host_rdata, 32'h0000_00B3);
        check("R8 b2b ready3", {31'b0, host_ready}, 32'h1);
        @(negedge clk);
        check("R8 ready single pulse", {31'b0, host_ready}, 32'h0);
    endtask

    task automatic t_irq;
        @(negedge clk); dev_intrq = 1'b1;
        @(negedge clk);
        check("R9 pending set", {31'b0, host_irq}, 32'h1);
        access(32'h0000_0080, 2'd0, 1'b0, '0);
        check("R9 alt status keeps irq", {31'b0, host_irq}, 32'h1);
        access(32'h0000_0070, 2'd0, 1'b0, '0);
        check("R9 status read clears", {31'b0, host_irq}, 32'h0);
        dev_intrq = 1'b0;
        access(32'h0000_0160, 2'd0, 1'b1, 32'h0000_0002);
        @(negedge clk); dev_intrq = 1'b1;
        @(negedge clk);
        check("R10 disabled masks irq", {31'b0, host_irq}, 32'h0);
        access(32'h0000_0080, 2'd0, 1'b1, 32'h0000_0000);
        check("R10 enable shows pending", {31'b0, host_irq}, 32'h1);
        access(32'h0000_0070, 2'd0, 1'b0, '0);
        check("R9 cleared again", {31'b0, host_irq}, 32'h0);
        dev_intrq = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_taskfile();
        t_ctrl();
        t_unmapped();
        t_data();
        t_back_to_back();
        t_irq();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule